// File: doc/BRIEF.md
# Segment Translation and Protection Unit

This unit turns a logical address, made of a segment number and an offset, into a physical address. It uses a small segment table held inside the block. Each table entry holds four things: a base, which is the physical start of the segment; a limit, which is the segment length in bytes; a valid flag; and three permission flags for read, write and execute. A separate segment-count register says how many entries are in use.

Every request passes four legality tests in a fixed order:

1. The segment number must be below the count.
2. The entry must be valid.
3. The offset must be below the limit.
4. The requested access kind must be permitted.

The first test that fails sets a trap code in the response. When all four tests pass, the response carries base plus offset and asserts a physical-address strobe.

Requests enter on a valid/ready handshake. Responses leave on a valid/ready handshake. The rules are:

- A request is accepted on a rising edge where `req_valid` and `req_ready` are both high.
- Its response is visible from that edge onward. The latency is therefore a fixed single cycle.
- A response is held unchanged until it is taken on an edge where `rsp_valid` and `rsp_ready` are both high.
- `req_ready` is high whenever the output holds no response, or the held response is being taken in the same cycle. This means a stalled consumer stalls the producer with no bubble in between.

Table entries and the count are loaded through a plain configuration write port.

Top module: `seg_xlate_unit`

## Requirements
- R1: A request accepted at a rising edge gives `rsp_valid` high right after that edge, carrying that request's result. If no request is accepted and the held response is taken, `rsp_valid` is low after the edge.
- R2: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and `rsp_paddr`, `rsp_trap` and `rsp_pa_valid` stay unchanged. Raising `rsp_ready` lets a waiting request be accepted on the same edge that takes the held response.
- R3: A segment number greater than or equal to the count gives trap code 1. A count written above the table size (16) is stored as 16.
- R4: A segment that passes R3 but whose entry valid flag is 0 gives trap code 2.
- R5: An offset greater than or equal to the entry limit gives trap code 3. A limit of 0 makes every offset trap.
- R6: The access kind is encoded as 0 for read, 1 for write, 2 for execute and 3 for reserved. Permission bits are bit 0 read, bit 1 write, bit 2 execute. A kind whose bit is clear gives trap code 4, and kind 3 always gives trap code 4.
- R7: When several tests fail, the reported code is the first failing test in the order R3, R4, R5, R6.
- R8: A request that passes all tests gives trap code 0, `rsp_pa_valid` high, and `rsp_paddr` equal to base plus offset modulo 2^32.
- R9: A trapped response has `rsp_pa_valid` low and `rsp_paddr` equal to 0.
- R10: An entry write with `cfg_ent_we` stores base, limit, valid and permissions at index `cfg_ent_idx`. A count write with `cfg_cnt_we` stores the count. Either write affects only requests accepted on later edges than the write's edge.
- R11: After reset, `rsp_valid` is low, the count is 0, and every entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_ent_we | input | 1 | Write one table entry |
| cfg_ent_idx | input | 4 | Entry index for the write |
| cfg_ent_base | input | 32 | Segment base to store |
| cfg_ent_limit | input | 32 | Segment length to store |
| cfg_ent_valid | input | 1 | Valid flag to store |
| cfg_ent_perm | input | 3 | Permissions to store: bit 0 read, bit 1 write, bit 2 execute |
| cfg_cnt_we | input | 1 | Write the segment count |
| cfg_cnt | input | 5 | Segment count value, clamped to 16 |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_seg | input | 6 | Segment number |
| req_off | input | 32 | Offset within the segment |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_pa_valid | output | 1 | Physical-address strobe, high only on a legal access |
| rsp_paddr | output | 32 | Physical address, 0 on a trap |
| rsp_trap | output | 3 | Trap code: 0 none, 1 segment range, 2 invalid, 3 bounds, 4 permission |

## Verification
The bench probes each of these edges directly:

- **Offset at the boundary.** It tries offsets at exactly the limit and one below it. A design that compares with greater-than instead of greater-or-equal lets a one-past-the-end access through.
- **Segment at the boundary.** It tries segment numbers equal to the count, and a count written above the table size. A wrong comparison or a missing clamp either admits an unloaded entry or rejects a loaded one.
- **Trap priority.** It sends requests that fail two tests at once. A wrong priority order reports the later trap.
- **Wrap-around.** It uses a base near the top of the address space, where a wrongly sized adder gives a wrong wrapped address.
- **Back-pressure.** It stalls the output while a second request waits. A design that drops or overwrites the held response, or loses the waiting request, shows it there.
- **Same-cycle write.** It issues a table write together with a request, so a write that leaks into the request in flight shows up.

// File: rtl/segxlat_pkg.sv
package segxlat_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [2:0] {
    TRAP_NONE    = 3'd0,
    TRAP_SEG     = 3'd1,
    TRAP_INVALID = 3'd2,
    TRAP_BOUNDS  = 3'd3,
    TRAP_PERM    = 3'd4
  } trap_e;

  localparam int PERM_W = 3;

  // permission bit order: read, write, execute
  function automatic logic kind_allowed(input logic [PERM_W-1:0] perm,
                                        input logic [1:0] kind);
    logic ok;
    case (acc_kind_e'(kind))
      ACC_READ:  ok = perm[0];
      ACC_WRITE: ok = perm[1];
      ACC_EXEC:  ok = perm[2];
      default:   ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/seg_table.sv
module seg_table
  import segxlat_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = $clog2(ENTRIES),
  parameter int CNT_W   = $clog2(ENTRIES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ent_we,
  input  logic [IDX_W-1:0]  ent_idx,
  input  logic [ADDR_W-1:0] ent_base,
  input  logic [ADDR_W-1:0] ent_limit,
  input  logic              ent_valid,
  input  logic [PERM_W-1:0] ent_perm,
  input  logic              cnt_we,
  input  logic [CNT_W-1:0]  cnt_in,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [ADDR_W-1:0] rd_base,
  output logic [ADDR_W-1:0] rd_limit,
  output logic              rd_valid,
  output logic [PERM_W-1:0] rd_perm,
  output logic [CNT_W-1:0]  cnt_q
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(ENTRIES);

  logic [ADDR_W-1:0] base_q  [ENTRIES];
  logic [ADDR_W-1:0] limit_q [ENTRIES];
  logic [PERM_W-1:0] perm_q  [ENTRIES];
  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] hit;

  // one-hot decode of the write index, one comparator per slot
  for (genvar g = 0; g < ENTRIES; g++) begin : g_dec
    assign hit[g] = ent_we && (ent_idx == IDX_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        base_q[i]  <= '0;
        limit_q[i] <= '0;
        perm_q[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (hit[i]) begin
          base_q[i]  <= ent_base;
          limit_q[i] <= ent_limit;
          perm_q[i]  <= ent_perm;
          valid_q[i] <= ent_valid;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_we) begin
      cnt_q <= (cnt_in > CNT_MAX) ? CNT_MAX : cnt_in;
    end
  end

  assign rd_base  = base_q[rd_idx];
  assign rd_limit = limit_q[rd_idx];
  assign rd_perm  = perm_q[rd_idx];
  assign rd_valid = valid_q[rd_idx];

endmodule

// File: rtl/seg_check.sv
module seg_check
  import segxlat_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SEG_W  = 6,
  parameter int CNT_W  = 5
) (
  input  logic [SEG_W-1:0]  seg,
  input  logic [ADDR_W-1:0] off,
  input  logic [1:0]        kind,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [ADDR_W-1:0] e_base,
  input  logic [ADDR_W-1:0] e_limit,
  input  logic              e_valid,
  input  logic [PERM_W-1:0] e_perm,
  output trap_e             trap,
  output logic [ADDR_W-1:0] paddr
);

  localparam int CMP_W = ((SEG_W > CNT_W) ? SEG_W : CNT_W) + 1;

  logic seg_ok, in_bounds, perm_ok;

  assign seg_ok    = CMP_W'(seg) < CMP_W'(cnt);
  assign in_bounds = off < e_limit;
  assign perm_ok   = kind_allowed(e_perm, kind);

  // first failing test wins
  always_comb begin
    if (!seg_ok)         trap = TRAP_SEG;
    else if (!e_valid)   trap = TRAP_INVALID;
    else if (!in_bounds) trap = TRAP_BOUNDS;
    else if (!perm_ok)   trap = TRAP_PERM;
    else                 trap = TRAP_NONE;
  end

  assign paddr = (trap == TRAP_NONE) ? (e_base + off) : '0;

endmodule

// File: rtl/seg_rsp_reg.sv
module seg_rsp_reg #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              take,
  input  logic [2:0]        trap_in,
  input  logic [ADDR_W-1:0] paddr_in,
  output logic              vld_q,
  output logic [2:0]        trap_q,
  output logic [ADDR_W-1:0] paddr_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      trap_q  <= '0;
      paddr_q <= '0;
    end else if (load) begin
      vld_q   <= 1'b1;
      trap_q  <= trap_in;
      paddr_q <= paddr_in;
    end else if (take) begin
      vld_q <= 1'b0;
    end
  end

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import segxlat_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 32,
  parameter int SEG_W   = 6,
  parameter int IDX_W   = $clog2(ENTRIES),
  parameter int CNT_W   = $clog2(ENTRIES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_ent_we,
  input  logic [IDX_W-1:0]  cfg_ent_idx,
  input  logic [ADDR_W-1:0] cfg_ent_base,
  input  logic [ADDR_W-1:0] cfg_ent_limit,
  input  logic              cfg_ent_valid,
  input  logic [2:0]        cfg_ent_perm,
  input  logic              cfg_cnt_we,
  input  logic [CNT_W-1:0]  cfg_cnt,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SEG_W-1:0]  req_seg,
  input  logic [ADDR_W-1:0] req_off,
  input  logic [1:0]        req_kind,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_pa_valid,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic [2:0]        rsp_trap
);

  logic [ADDR_W-1:0] e_base, e_limit, chk_paddr;
  logic              e_valid;
  logic [PERM_W-1:0] e_perm;
  logic [CNT_W-1:0]  seg_cnt;
  trap_e             chk_trap;
  logic              accept;

  seg_table #(
    .ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_tab (
    .clk      (clk),
    .rst_n    (rst_n),
    .ent_we   (cfg_ent_we),
    .ent_idx  (cfg_ent_idx),
    .ent_base (cfg_ent_base),
    .ent_limit(cfg_ent_limit),
    .ent_valid(cfg_ent_valid),
    .ent_perm (cfg_ent_perm),
    .cnt_we   (cfg_cnt_we),
    .cnt_in   (cfg_cnt),
    .rd_idx   (req_seg[IDX_W-1:0]),
    .rd_base  (e_base),
    .rd_limit (e_limit),
    .rd_valid (e_valid),
    .rd_perm  (e_perm),
    .cnt_q    (seg_cnt)
  );

  seg_check #(
    .ADDR_W(ADDR_W), .SEG_W(SEG_W), .CNT_W(CNT_W)
  ) u_chk (
    .seg    (req_seg),
    .off    (req_off),
    .kind   (req_kind),
    .cnt    (seg_cnt),
    .e_base (e_base),
    .e_limit(e_limit),
    .e_valid(e_valid),
    .e_perm (e_perm),
    .trap   (chk_trap),
    .paddr  (chk_paddr)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  seg_rsp_reg #(.ADDR_W(ADDR_W)) u_rsp (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .take    (rsp_ready),
    .trap_in (chk_trap),
    .paddr_in(chk_paddr),
    .vld_q   (rsp_valid),
    .trap_q  (rsp_trap),
    .paddr_q (rsp_paddr)
  );

  assign rsp_pa_valid = rsp_valid && (rsp_trap == TRAP_NONE);

endmodule

// File: rtl/seg_xlate_sva.sv
module seg_xlate_sva #(
  parameter int ADDR_W = 32,
  parameter int SEG_W  = 6,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [SEG_W-1:0]  req_seg,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_pa_valid,
  input logic [ADDR_W-1:0] rsp_paddr,
  input logic [2:0]        rsp_trap,
  input logic [CNT_W-1:0]  cnt
);

  localparam int CMP_W = ((SEG_W > CNT_W) ? SEG_W : CNT_W) + 1;

  a_r1_accept_gives_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  a_r1_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(req_valid && req_ready));

  a_r2_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr)
                               && $stable(rsp_trap) && $stable(rsp_pa_valid));

  a_r2_block_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);

  a_r3_seg_range_trap: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (CMP_W'(req_seg) >= CMP_W'(cnt)) |=> rsp_trap == 3'd1);

  a_r3_count_clamped: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(16));

  a_r9_no_strobe_on_trap: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_trap != 3'd0 |-> !rsp_pa_valid && rsp_paddr == '0);

  a_r8_strobe_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_pa_valid |-> rsp_valid);

endmodule

bind seg_xlate_unit seg_xlate_sva #(
  .ADDR_W(ADDR_W), .SEG_W(SEG_W), .CNT_W(CNT_W)
) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_seg     (req_seg),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_pa_valid(rsp_pa_valid),
  .rsp_paddr   (rsp_paddr),
  .rsp_trap    (rsp_trap),
  .cnt         (seg_cnt)
);

// File: tb/seg_xlate_unit_tb.sv
`timescale 1ns/1ps
module seg_xlate_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_ent_we = 1'b0;
  logic [3:0]  cfg_ent_idx = '0;
  logic [31:0] cfg_ent_base = '0;
  logic [31:0] cfg_ent_limit = '0;
  logic        cfg_ent_valid = 1'b0;
  logic [2:0]  cfg_ent_perm = '0;
  logic        cfg_cnt_we = 1'b0;
  logic [4:0]  cfg_cnt = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [5:0]  req_seg = '0;
  logic [31:0] req_off = '0;
  logic [1:0]  req_kind = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_pa_valid;
  logic [31:0] rsp_paddr;
  logic [2:0]  rsp_trap;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  seg_xlate_unit u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_ent_we(cfg_ent_we), .cfg_ent_idx(cfg_ent_idx),
    .cfg_ent_base(cfg_ent_base), .cfg_ent_limit(cfg_ent_limit),
    .cfg_ent_valid(cfg_ent_valid), .cfg_ent_perm(cfg_ent_perm),
    .cfg_cnt_we(cfg_cnt_we), .cfg_cnt(cfg_cnt),
    .req_valid(req_valid), .req_ready(req_ready), .req_seg(req_seg),
    .req_off(req_off), .req_kind(req_kind),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_pa_valid(rsp_pa_valid), .rsp_paddr(rsp_paddr), .rsp_trap(rsp_trap)
  );

  typedef struct packed {
    logic [5:0]  seg;
    logic [31:0] off;
    logic [1:0]  kind;
    logic [2:0]  trap;
    logic [31:0] pa;
    logic [3:0]  rq;
  } vec_t;

  // kind: 0 rd, 1 wr, 2 ex, 3 rsvd; trap: 0 ok,1 seg,2 invalid,3 bounds,4 perm
  localparam vec_t VECS [15] = '{
    '{6'd0,  32'h10,       2'd0, 3'd0, 32'h1000_0010, 4'd8},
    '{6'd0,  32'hFF,       2'd1, 3'd0, 32'h1000_00FF, 4'd5},
    '{6'd0,  32'h100,      2'd0, 3'd3, 32'h0,         4'd5},
    '{6'd0,  32'h10,       2'd2, 3'd4, 32'h0,         4'd6},
    '{6'd1,  32'h3F,       2'd2, 3'd0, 32'h2000_003F, 4'd8},
    '{6'd1,  32'h0,        2'd0, 3'd4, 32'h0,         4'd6},
    '{6'd2,  32'h0,        2'd0, 3'd2, 32'h0,         4'd4},
    '{6'd2,  32'h200,      2'd2, 3'd2, 32'h0,         4'd7},
    '{6'd3,  32'h20,       2'd0, 3'd0, 32'h0000_0010, 4'd8},
    '{6'd3,  32'h20,       2'd1, 3'd4, 32'h0,         4'd6},
    '{6'd4,  32'h0,        2'd0, 3'd3, 32'h0,         4'd5},
    '{6'd5,  32'h0,        2'd0, 3'd1, 32'h0,         4'd3},
    '{6'd63, 32'hFFFF_FFFF, 2'd3, 3'd1, 32'h0,        4'd7},
    '{6'd0,  32'h10,       2'd3, 3'd4, 32'h0,         4'd6},
    '{6'd1,  32'h40,       2'd0, 3'd3, 32'h0,         4'd7}
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  function automatic string rq_name(input logic [3:0] n);
    case (n)
      4'd3: return "R3 seg range";
      4'd4: return "R4 invalid";
      4'd5: return "R5 bounds";
      4'd6: return "R6 permission";
      4'd7: return "R7 priority";
      default: return "R8 legal";
    endcase
  endfunction

  task automatic wr_ent(input logic [3:0] idx, input logic [31:0] b, input logic [31:0] l,
                        input logic v, input logic [2:0] p);
    @(negedge clk);
    cfg_ent_we = 1'b1; cfg_ent_idx = idx; cfg_ent_base = b;
    cfg_ent_limit = l; cfg_ent_valid = v; cfg_ent_perm = p;
    @(negedge clk);
    cfg_ent_we = 1'b0;
  endtask

  task automatic wr_cnt(input logic [4:0] c);
    @(negedge clk);
    cfg_cnt_we = 1'b1; cfg_cnt = c;
    @(negedge clk);
    cfg_cnt_we = 1'b0;
  endtask

  // one request; result sampled at the negedge after the accepting edge
  task automatic do_req(input logic [5:0] s, input logic [31:0] o, input logic [1:0] k,
                        output logic [2:0] t, output logic [31:0] pa, output logic pv);
    @(negedge clk);
    req_valid = 1'b1; req_seg = s; req_off = o; req_kind = k;
    @(negedge clk);
    chk("R1 response after one edge", 32'(rsp_valid), 32'd1);
    t = rsp_trap; pa = rsp_paddr; pv = rsp_pa_valid;
    req_valid = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2:0] t;
    logic [31:0] pa;
    logic pv;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    chk("R2 req_ready when empty", 32'(req_ready), 32'd1);

    // R11/R3: count is 0 after reset
    do_req(6'd0, 32'h0, 2'd0, t, pa, pv);
    chk("R11 count zero gives seg trap", 32'(t), 32'd1);
    chk("R9 no strobe on trap", 32'(pv), 32'd0);
    @(negedge clk);
    chk("R1 rsp_valid drops when idle", 32'(rsp_valid), 32'd0);

    // R11: entries invalid after reset
    wr_cnt(5'd16);
    do_req(6'd7, 32'h0, 2'd0, t, pa, pv);
    chk("R11 entries invalid after reset", 32'(t), 32'd2);

    // R3: count above 16 clamps to 16
    wr_cnt(5'd31);
    do_req(6'd15, 32'h0, 2'd0, t, pa, pv);
    chk("R3 clamp keeps seg 15 in range", 32'(t), 32'd2);
    do_req(6'd16, 32'h0, 2'd0, t, pa, pv);
    chk("R3 clamp rejects seg 16", 32'(t), 32'd1);

    // R10 table load
    wr_ent(4'd0, 32'h1000_0000, 32'h100, 1'b1, 3'b011);
    wr_ent(4'd1, 32'h2000_0000, 32'h40,  1'b1, 3'b100);
    wr_ent(4'd2, 32'h3000_0000, 32'h80,  1'b0, 3'b111);
    wr_ent(4'd3, 32'hFFFF_FFF0, 32'h100, 1'b1, 3'b001);
    wr_ent(4'd4, 32'h0000_4000, 32'h0,   1'b1, 3'b111);
    wr_cnt(5'd5);

    for (int i = 0; i < 15; i++) begin
      do_req(VECS[i].seg, VECS[i].off, VECS[i].kind, t, pa, pv);
      chk(rq_name(VECS[i].rq), 32'(t), 32'(VECS[i].trap));
      chk("R9 paddr and strobe", pa, (VECS[i].trap == 3'd0) ? VECS[i].pa : 32'h0);
      chk("R8 strobe only when legal", 32'(pv), 32'(VECS[i].trap == 3'd0));
    end

    // R2 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_seg = 6'd0; req_off = 32'h1; req_kind = 2'd0;
    @(negedge clk);
    req_seg = 6'd1; req_off = 32'h2; req_kind = 2'd2;
    chk("R2 first response present", 32'(rsp_valid), 32'd1);
    chk("R2 req_ready low when full", 32'(req_ready), 32'd0);
    repeat (2) @(negedge clk);
    chk("R2 held paddr", rsp_paddr, 32'h1000_0001);
    chk("R2 still blocked", 32'(req_ready), 32'd0);
    rsp_ready = 1'b1;
    #1;
    chk("R2 ready follows consumer", 32'(req_ready), 32'd1);
    @(negedge clk);
    chk("R2 waiting request taken", rsp_paddr, 32'h2000_0002);
    chk("R2 waiting request valid", 32'(rsp_valid), 32'd1);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R1 idle after drain", 32'(rsp_valid), 32'd0);

    // R10 write in same cycle as request affects only later requests
    @(negedge clk);
    req_valid = 1'b1; req_seg = 6'd0; req_off = 32'h10; req_kind = 2'd0;
    cfg_ent_we = 1'b1; cfg_ent_idx = 4'd0; cfg_ent_base = 32'h5000_0000;
    cfg_ent_limit = 32'h100; cfg_ent_valid = 1'b1; cfg_ent_perm = 3'b011;
    cfg_cnt_we = 1'b1; cfg_cnt = 5'd0;
    @(negedge clk);
    req_valid = 1'b0; cfg_ent_we = 1'b0; cfg_cnt_we = 1'b0;
    chk("R10 same-cycle write unseen", rsp_paddr, 32'h1000_0010);
    wr_cnt(5'd5);
    do_req(6'd0, 32'h10, 2'd0, t, pa, pv);
    chk("R10 new base used later", pa, 32'h5000_0010);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule